// File: doc/BRIEF.md
# Eight-Lane Pulse-Width LED Burst Generator

This block drives eight serial LED data lines at once. All lanes share one bit-cell timing. A 1 goes out as a long high pulse and a 0 as a short one. One data byte feeds one cell, and bit i of the byte goes to lane i.

A free-running cell counter counts from 0 up to a programmed last value P, so a cell lasts P+1 clocks. Two compare values split the cell into three parts:

- When the counter equals the rise point C1, every lane is driven high.
- When it equals the data point C2, each lane takes its bit of the current byte.
- When it equals P, every lane is driven low.

Each of these changes shows on the lane pins one clock after the counter holds the value. The block sends a programmed count of cells, stops after the last one and holds the lanes low until the next start strobe.

The start strobe latches the timing values and the burst length. The latched values must satisfy C1 < C2 < P. The burst length L is the cell count minus one. Bytes arrive through a ready/valid input. A missing byte turns into an all-zero cell and sets an underrun flag.

Top module: `ledwave_burst`

## Requirements
- R1: Lane i carries bit i of the cell's byte. A 1 keeps the lane high for P-C1 clocks and a 0 keeps it high for C2-C1 clocks.
- R2: On the clock after the counter equals C1, all eight lanes read high (8'hFF).
- R3: On the clock after the counter equals C2, the lanes equal the cell's data byte, and they hold that value until the end of the cell.
- R4: On the clock after the counter equals P, all lanes read low. They stay low through counter value C1 of the following cell.
- R5: A burst length value L sends exactly L+1 cells. The busy flag reads 1 for (L+1)*(P+1) consecutive clocks, starting with the clock after the edge that samples start.
- R6: The first cell of a burst has the same timing as every later cell. The lanes stay low for C1+1 clocks after the start edge and then rise.
- R7: After the final cell the lanes stay low and busy stays 0 until a new start. A start strobe that arrives while busy is high has no effect.
- R8: The done flag is high for exactly one clock. That clock is the first clock of the final low phase, the same clock in which busy first reads 0.
- R9: One byte is taken per cell through ready/valid, in order. The byte for a cell may be taken up to and including the clock in which the counter equals C2. Ready is low whenever busy is low.
- R10: If no byte has been taken for a cell when the counter reaches C2, that cell outputs 8'h00. The underrun flag then reads 1 until the next accepted start, which clears it.
- R11: The period, compare and length values are latched when an accepted start is sampled. Changes on those inputs during a burst have no effect on that burst.
- R12: During and after reset the lane pins, busy, done, ready and underrun all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; accepted only while idle |
| period_i | input | CNT_W | Last counter value P of a cell (cell length P+1) |
| rise_at_i | input | CNT_W | Counter value C1 at which all lanes rise |
| data_at_i | input | CNT_W | Counter value C2 at which lanes take the data byte |
| last_idx_i | input | LEN_W | Number of cells in the burst minus one |
| data_i | input | LANES | Cell byte, bit i for lane i |
| data_valid_i | input | 1 | Byte on data_i is valid |
| data_ready_o | output | 1 | Block can take a byte this clock |
| lanes_o | output | LANES | Registered lane pins |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-clock pulse at start of final low phase |
| underrun_o | output | 1 | A cell had no byte by its data point |

## Verification
The bound checker watches a set of properties on every clock:

- Lanes change only in legal steps: from low to all-high, from all-high to a subset, or down to all-low.
- Lanes are low while idle.
- Done is a single clock that falls exactly where busy drops.
- Ready is low while idle, and the block stays idle until a start arrives.

Other behaviour needs the bench's cycle-exact reference model under chosen scenarios:

- The exact clocks of each transition.
- Equal timing of the first cell and the later cells.
- The cell count per burst.
- Byte ordering and the mapping of bits to lanes.
- Underrun zeros.
- Starts ignored mid-burst, latched configuration, and back-to-back bursts.

// File: rtl/ledwave_pkg.sv
package ledwave_pkg;

  // Event raised by the cell timer for the current counter value.
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_RISE = 2'd1,
    EV_DATA = 2'd2,
    EV_END  = 2'd3
  } cell_ev_e;

endpackage

// File: rtl/ledwave_cell_timer.sv
module ledwave_cell_timer
  import ledwave_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] rise_at_i,
  input  logic [CNT_W-1:0] data_at_i,
  input  logic [LEN_W-1:0] last_idx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             accept_o,
  output logic             last_cell_o,
  output cell_ev_e         ev_o
);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q, per_q, rise_q, data_q;
  logic [LEN_W-1:0] cell_q, len_q;
  logic             at_end, at_last;

  assign accept_o = start_i && !busy_q;
  assign at_end   = (cnt_q == per_q);
  assign at_last  = (cell_q == len_q);

  // Counter, cell index and latched configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      cell_q <= '0;
      per_q  <= '0;
      rise_q <= '0;
      data_q <= '0;
      len_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          cell_q <= '0;
          per_q  <= period_i;
          rise_q <= rise_at_i;
          data_q <= data_at_i;
          len_q  <= last_idx_i;
        end
      end else if (at_end) begin
        cnt_q <= '0;
        if (at_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cell_q <= cell_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Compare decode; cell end has priority over the two compare points
  always_comb begin
    ev_o = EV_NONE;
    if (busy_q) begin
      if (at_end)                ev_o = EV_END;
      else if (cnt_q == data_q)  ev_o = EV_DATA;
      else if (cnt_q == rise_q)  ev_o = EV_RISE;
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign last_cell_o = at_last;

endmodule

// File: rtl/ledwave_byte_stage.sv
module ledwave_byte_stage
  import ledwave_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             busy_i,
  input  logic             last_cell_i,
  input  cell_ev_e         ev_i,
  input  logic [LANES-1:0] data_i,
  input  logic             data_valid_i,
  output logic             data_ready_o,
  output logic [LANES-1:0] cell_byte_o,
  output logic             underrun_o
);

  logic             have_q, spent_q, under_q;
  logic [LANES-1:0] byte_q;
  logic             take;

  // One byte per cell; no byte is taken after the last cell's data point
  assign data_ready_o = busy_i && !have_q && !(last_cell_i && spent_q);
  assign take         = data_ready_o && data_valid_i;

  // Byte taken on the data-point clock goes straight to the lanes
  always_comb begin
    if (have_q)    cell_byte_o = byte_q;
    else if (take) cell_byte_o = data_i;
    else           cell_byte_o = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q  <= 1'b0;
      spent_q <= 1'b0;
      under_q <= 1'b0;
      byte_q  <= '0;
    end else if (clear_i) begin
      have_q  <= 1'b0;
      spent_q <= 1'b0;
      under_q <= 1'b0;
    end else begin
      if (ev_i == EV_DATA) begin
        spent_q <= 1'b1;
        have_q  <= 1'b0;
        if (!have_q && !take) under_q <= 1'b1;
      end else if (take) begin
        have_q <= 1'b1;
        byte_q <= data_i;
      end
      if (ev_i == EV_END) spent_q <= 1'b0;
    end
  end

  assign underrun_o = under_q;

endmodule

// File: rtl/ledwave_lane_drv.sv
module ledwave_lane_drv
  import ledwave_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  cell_ev_e         ev_i,
  input  logic [LANES-1:0] cell_byte_i,
  output logic [LANES-1:0] lanes_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic pin_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_q <= 1'b0;
      end else begin
        case (ev_i)
          EV_RISE: pin_q <= 1'b1;
          EV_DATA: pin_q <= cell_byte_i[g];
          EV_END:  pin_q <= 1'b0;
          default: pin_q <= pin_q;
        endcase
      end
    end
    assign lanes_o[g] = pin_q;
  end

endmodule

// File: rtl/ledwave_burst.sv
module ledwave_burst
  import ledwave_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] rise_at_i,
  input  logic [CNT_W-1:0] data_at_i,
  input  logic [LEN_W-1:0] last_idx_i,
  input  logic [LANES-1:0] data_i,
  input  logic             data_valid_i,
  output logic             data_ready_o,
  output logic [LANES-1:0] lanes_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underrun_o
);

  cell_ev_e         ev;
  logic             accept, last_cell;
  logic [LANES-1:0] cell_byte;

  ledwave_cell_timer #(.CNT_W(CNT_W), .LEN_W(LEN_W)) timer_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .period_i    (period_i),
    .rise_at_i   (rise_at_i),
    .data_at_i   (data_at_i),
    .last_idx_i  (last_idx_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .accept_o    (accept),
    .last_cell_o (last_cell),
    .ev_o        (ev)
  );

  ledwave_byte_stage #(.LANES(LANES)) bytes_i (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (accept),
    .busy_i       (busy_o),
    .last_cell_i  (last_cell),
    .ev_i         (ev),
    .data_i       (data_i),
    .data_valid_i (data_valid_i),
    .data_ready_o (data_ready_o),
    .cell_byte_o  (cell_byte),
    .underrun_o   (underrun_o)
  );

  ledwave_lane_drv #(.LANES(LANES)) lanes_i (
    .clk         (clk),
    .rst         (rst),
    .ev_i        (ev),
    .cell_byte_i (cell_byte),
    .lanes_o     (lanes_o)
  );

endmodule

// File: rtl/ledwave_burst_chk.sv
module ledwave_burst_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             data_ready_o,
  input logic [LANES-1:0] lanes_o
);

  AST_IDLE_LANES_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> lanes_o == '0);                                          // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> !busy_o);                                  // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);                                                 // R8

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o) && lanes_o == '0));             // R8

  AST_LANE_STEPS: assert property (@(posedge clk) disable iff (rst)
    (lanes_o != $past(lanes_o)) |->
      (lanes_o == '1 || lanes_o == '0 || $past(lanes_o) == '1));         // R2

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !data_ready_o);                                          // R9

endmodule

bind ledwave_burst ledwave_burst_chk #(.LANES(LANES)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .data_ready_o (data_ready_o),
  .lanes_o      (lanes_o)
);

// File: tb/ledwave_burst_tb_top.sv
module ledwave_burst_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int CW = 16;
  localparam int LW = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [CW-1:0] per = '0, c1 = '0, c2 = '0;
  logic [LW-1:0] len = '0;
  logic [LANES-1:0] din = '0;
  logic dval = 1'b0;
  logic rdy, busy, done, und;
  logic [LANES-1:0] lanes;

  ledwave_burst #(.LANES(LANES), .CNT_W(CW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .period_i(per), .rise_at_i(c1),
    .data_at_i(c2), .last_idx_i(len), .data_i(din), .data_valid_i(dval),
    .data_ready_o(rdy), .lanes_o(lanes), .busy_o(busy), .done_o(done),
    .underrun_o(und)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errs = 0, checks = 0;
  logic [7:0] feed[$];
  logic [7:0] nxt[$];
  logic [7:0] cur[$];
  int jcnt = -1;
  int mP = 0, mC1 = 0, mC2 = 0, mL = 0, mN = 0;
  logic und_exp = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: time since the accepted start edge, plus byte source
  always @(posedge clk) begin
    if (rdy && dval && feed.size() > 0) void'(feed.pop_front());
    if (rst) begin
      jcnt = -1;
    end else if (jcnt < 0 || jcnt >= (mL + 1) * (mP + 1)) begin
      if (start) begin
        mP = int'(per); mC1 = int'(c1); mC2 = int'(c2); mL = int'(len);
        cur = nxt; mN = cur.size();
        jcnt = 0;
      end else begin
        jcnt = -1;
      end
    end else begin
      jcnt++;
    end
  end

  always @(negedge clk) begin
    din  = (feed.size() > 0) ? feed[0] : '0;
    dval = (feed.size() > 0);
    if (!rst) begin
      logic [7:0] el;
      logic eb, ed;
      string tg;
      el = '0; eb = 1'b0; ed = 1'b0; tg = "R7";
      if (jcnt == 0) begin
        eb = 1'b1; und_exp = 1'b0; tg = "R6";
      end else if (jcnt > 0) begin
        int q, r, k, e;
        q = jcnt - 1; r = q % (mP + 1); k = q / (mP + 1);
        e = (mL + 1) * (mP + 1) - 1;
        eb = (q < e); ed = (q == e);
        if (r < mC1)      begin el = 8'h00; tg = "R4"; end
        else if (r < mC2) begin el = 8'hFF; tg = "R2"; end
        else if (r < mP)  begin el = (k < mN) ? cur[k] : 8'h00; tg = "R3 R1"; end
        else              begin el = 8'h00; tg = "R4"; end
        if (k == 0 && r <= mC1) tg = "R6";
        und_exp = (mN <= mL) && (q >= mN * (mP + 1) + mC2);
      end
      chk(lanes == el, tg, "lanes", int'(lanes), int'(el));
      chk(busy == eb, "R5", "busy", int'(busy), int'(eb));
      chk(done == ed, "R8", "done", int'(done), int'(ed));
      chk(und == und_exp, "R10", "underrun", int'(und), int'(und_exp));
      if (!eb) chk(!rdy, "R9", "ready while idle", int'(rdy), 0);
    end
  end

  // Called at a negedge; returns at the negedge showing done
  task automatic run_burst(input int p, input int a, input int b, input int l,
                           input logic [7:0] bytes[$], input bit disturb);
    per = CW'(p); c1 = CW'(a); c2 = CW'(b); len = LW'(l);
    nxt = bytes;
    foreach (bytes[i]) feed.push_back(bytes[i]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < (l + 1) * (p + 1); i++) begin
      if (disturb && i == 10) begin
        // R11 new values ignored, R7 start ignored while busy
        per = CW'(3); c1 = CW'(0); c2 = CW'(1); len = LW'(0); start = 1'b1;
      end
      if (disturb && i == 11) start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(lanes == '0, "R12", "reset lanes", int'(lanes), 0);
    chk(!busy && !done, "R12", "reset busy/done", int'({busy, done}), 0);
    chk(!rdy && !und, "R12", "reset ready/underrun", int'({rdy, und}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run_burst(9, 2, 5, 4, '{8'h1B, 8'hA5, 8'hFF, 8'h00, 8'h3C}, 1'b0);
    repeat (4) @(negedge clk);
    run_burst(5, 0, 1, 0, '{8'h81}, 1'b0);
    repeat (3) @(negedge clk);
    run_burst(20, 4, 12, 7, '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80}, 1'b1);
    repeat (5) @(negedge clk);
    // R10 only two bytes for four cells
    run_burst(7, 1, 3, 3, '{8'hC3, 8'h5A}, 1'b0);
    repeat (6) @(negedge clk);
    // back-to-back bursts, data point one before the end; start clears R10 flag
    run_burst(6, 1, 5, 2, '{8'hF0, 8'h0F, 8'h99}, 1'b0);
    run_burst(6, 2, 4, 1, '{8'h66, 8'hE7}, 1'b0);
    repeat (8) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule